// File: doc/BRIEF.md
# Programmable Recursive Systematic Convolutional Encoder

This block turns a serial stream of information bits into rate 1/4 code symbols, one block at a time. The code is recursive and systematic with nine delay elements, so its trellis has 512 states. One feedback polynomial and three parity polynomials come from static configuration inputs, set the way a bank of switches would set them. Every polynomial keeps its constant and highest-order coefficients at 1. The remaining coefficients are free.

A pulse on `blk_start` clears the encoder memory and samples the polynomial inputs. The block then runs 128 trellis steps. The first 119 steps each take one information bit through a valid/ready handshake. The last nine steps are termination steps. In each termination step the encoder feeds back its own recursion value, so the memory empties to the all-zero state.

Trellis steps are paced to at most one every 525 clock cycles. This matches the per-step time budget of the decoder on the far end. Each step produces a one-cycle strobe carrying a 4-bit symbol: the systematic bit in bit 0 and the three parity bits above it.

Top module: `rsc_encoder`

## Requirements
- R1: After reset and until the first `blk_start`, `sym_valid` and `in_ready` stay low.
- R2: In every symbol, bit 0 is the systematic bit, and bit j (j = 1..3) is the parity of polynomial j. On the 119 information steps, bit 0 equals the accepted input bit.
- R3: Let s[i] be the recursion value from i steps back (i = 1..9) and take c[i] from configuration bit i. The recursion value is a = u XOR (XOR over i of fb[i]·s[i]), and parity j is gj[0]·a XOR (XOR over i of gj[i]·s[i]).
- R4: Each `blk_start` is followed by exactly 128 symbols. After that the block stays idle, with no symbol and no `in_ready`, until the next `blk_start`.
- R5: Steps 0..118 each consume exactly one input bit, taken on a cycle where `in_valid` and `in_ready` are both high. `in_ready` is never high during steps 119..127.
- R6: On steps 119..127 the systematic bit equals the feedback sum, so the recursion value is 0. The memory is all-zero after step 127.
- R7: `blk_start` clears the memory and restarts at step 0, even in the middle of a block. `in_ready` is low in the cycle `blk_start` is high, so input offered then is not taken.
- R8: Two consecutive symbols of a block are at least STEP_CYCLES clock cycles apart (default 525). They are exactly that far apart when input is always valid. A step waits while no input is valid.
- R9: `sym_valid` is high for a single cycle per step and low between steps.
- R10: The polynomial inputs are sampled only on `blk_start`. Changes during a block do not alter that block's symbols.
- R11: Configuration bits 0 and 9 of every polynomial are ignored and treated as 1.
- R12: A symbol appears on the clock edge after the handshake of its step, with `sym_valid` high in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| blk_start | input | 1 | Block start pulse; clears memory, samples polynomials |
| in_data | input | 1 | Information bit |
| in_valid | input | 1 | Information bit valid |
| in_ready | output | 1 | Encoder takes an information bit this cycle |
| cfg_fb | input | 10 | Feedback polynomial, bit i = coefficient of delay i |
| cfg_par | input | 30 | Three parity polynomials, polynomial j in bits [10(j-1)+9 : 10(j-1)] |
| sym_data | output | 4 | Code symbol: bit 0 systematic, bits 3:1 parity 3..1 |
| sym_valid | output | 1 | One-cycle strobe for `sym_data` |

## Verification
Blocks of all ones, all zeros, a 7-bit pseudo-random sequence and an alternating pattern are encoded under two polynomial sets. They are compared symbol by symbol with a model derived from the encoding equation. All-zero input under the sparse set shows whether the output is inverted or has a stray constant. All-ones input drives the recursion through its full cycle. The pseudo-random and alternating inputs separate individual feedback and parity taps, and they catch an off-by-one in delay order. Separate runs stall the input to exercise pacing and handshake timing, change the polynomials mid-block, clear the fixed end coefficients, and restart in the middle of a block. The bench shortens the step period to keep runs brief.

// File: rtl/rsc_pkg.sv
`timescale 1ns/1ps
package rsc_pkg;
  localparam int unsigned RSC_MEM_DEF   = 9;
  localparam int unsigned RSC_PAR_DEF   = 3;
  localparam int unsigned RSC_STEPS_DEF = 128;
  localparam int unsigned RSC_PACE_DEF  = 512 + 13;
  localparam int unsigned RSC_WORD_W    = 32;

  typedef logic [RSC_WORD_W-1:0] rsc_word_t;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_mode_e;

  // modulo-2 inner product of a tap mask and a delay line
  function automatic logic tap_sum(input rsc_word_t taps, input rsc_word_t line);
    return ^(taps & line);
  endfunction

  // recursion value: input bit plus feedback sum
  function automatic logic recur_bit(input logic u, input logic fb_sum);
    return u ^ fb_sum;
  endfunction
endpackage

// File: rtl/rsc_step_pacer.sv
`timescale 1ns/1ps
module rsc_step_pacer #(
  parameter int unsigned STEP_CYCLES = 525
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic fire,
  output logic pace_zero
);
  localparam int unsigned PACE_W = (STEP_CYCLES > 2) ? $clog2(STEP_CYCLES) : 1;
  localparam logic [PACE_W-1:0] RELOAD = PACE_W'(STEP_CYCLES - 1);

  logic [PACE_W-1:0] wait_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_cnt <= '0;
    end else if (restart) begin
      wait_cnt <= '0;
    end else if (fire) begin
      wait_cnt <= RELOAD;
    end else if (wait_cnt != '0) begin
      wait_cnt <= wait_cnt - 1'b1;
    end
  end

  assign pace_zero = (wait_cnt == '0);
endmodule

// File: rtl/rsc_block_seq.sv
`timescale 1ns/1ps
module rsc_block_seq
  import rsc_pkg::*;
#(
  parameter int unsigned BLK_STEPS  = 128,
  parameter int unsigned TAIL_STEPS = 9,
  parameter int unsigned IDX_W      = $clog2(BLK_STEPS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             fire,
  output logic             seq_active,
  output logic [IDX_W-1:0] step_idx,
  output logic             tail_step,
  output logic             last_step
);
  localparam logic [IDX_W-1:0] FIRST_TAIL = IDX_W'(BLK_STEPS - TAIL_STEPS);
  localparam logic [IDX_W-1:0] FINAL_IDX  = IDX_W'(BLK_STEPS - 1);

  seq_mode_e mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode     <= SEQ_IDLE;
      step_idx <= '0;
    end else if (restart) begin
      mode     <= SEQ_RUN;
      step_idx <= '0;
    end else if (fire) begin
      if (last_step) begin
        mode <= SEQ_IDLE;
      end else begin
        step_idx <= step_idx + 1'b1;
      end
    end
  end

  assign seq_active = (mode == SEQ_RUN);
  assign tail_step  = (step_idx >= FIRST_TAIL);
  assign last_step  = (step_idx == FINAL_IDX);
endmodule

// File: rtl/rsc_cfg_latch.sv
`timescale 1ns/1ps
module rsc_cfg_latch #(
  parameter int unsigned MEM   = 9,
  parameter int unsigned NPOLY = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       capture,
  input  logic [NPOLY*(MEM+1)-1:0]   raw_polys,
  output logic [NPOLY*(MEM+1)-1:0]   held_polys
);
  localparam int unsigned PW = MEM + 1;
  localparam logic [PW-1:0] END_TAPS = {1'b1, {(MEM-1){1'b0}}, 1'b1};

  for (genvar p = 0; p < NPOLY; p++) begin : g_poly
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        held_polys[p*PW +: PW] <= END_TAPS;
      end else if (capture) begin
        held_polys[p*PW +: PW] <= raw_polys[p*PW +: PW] | END_TAPS;
      end
    end
  end
endmodule

// File: rtl/rsc_trellis_core.sv
`timescale 1ns/1ps
module rsc_trellis_core
  import rsc_pkg::*;
#(
  parameter int unsigned MEM     = 9,
  parameter int unsigned NUM_PAR = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       restart,
  input  logic                       fire,
  input  logic                       tail_step,
  input  logic                       in_bit,
  input  logic [MEM:0]               fb_poly,
  input  logic [NUM_PAR*(MEM+1)-1:0] par_poly,
  output logic [NUM_PAR:0]           sym_data,
  output logic                       sym_valid,
  output logic [MEM-1:0]             enc_state,
  output logic                       fb_bit
);
  localparam int unsigned PW = MEM + 1;

  logic               sys_bit;
  logic               rec_bit;
  logic [NUM_PAR-1:0] par_next;

  assign fb_bit  = tap_sum(rsc_word_t'(fb_poly[MEM:1]), rsc_word_t'(enc_state));
  assign sys_bit = tail_step ? fb_bit : in_bit;
  assign rec_bit = recur_bit(sys_bit, fb_bit);

  for (genvar j = 0; j < NUM_PAR; j++) begin : g_par
    assign par_next[j] = (par_poly[j*PW] & rec_bit)
                       ^ tap_sum(rsc_word_t'(par_poly[j*PW+1 +: MEM]), rsc_word_t'(enc_state));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enc_state <= '0;
      sym_data  <= '0;
      sym_valid <= 1'b0;
    end else if (restart) begin
      enc_state <= '0;
      sym_valid <= 1'b0;
    end else if (fire) begin
      enc_state <= {enc_state[MEM-2:0], rec_bit};
      sym_data  <= {par_next, sys_bit};
      sym_valid <= 1'b1;
    end else begin
      sym_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/rsc_encoder.sv
`timescale 1ns/1ps
module rsc_encoder
  import rsc_pkg::*;
#(
  parameter int unsigned MEM         = RSC_MEM_DEF,
  parameter int unsigned NUM_PAR     = RSC_PAR_DEF,
  parameter int unsigned BLK_STEPS   = RSC_STEPS_DEF,
  parameter int unsigned STEP_CYCLES = RSC_PACE_DEF
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       blk_start,
  input  logic                       in_data,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [MEM:0]               cfg_fb,
  input  logic [NUM_PAR*(MEM+1)-1:0] cfg_par,
  output logic [NUM_PAR:0]           sym_data,
  output logic                       sym_valid
);
  localparam int unsigned PW    = MEM + 1;
  localparam int unsigned NPOLY = NUM_PAR + 1;
  localparam int unsigned IDX_W = $clog2(BLK_STEPS);

  // named internal events
  logic                   seq_active;
  logic [IDX_W-1:0]       step_idx;
  logic                   tail_step;
  logic                   last_step;
  logic                   pace_zero;
  logic                   step_elig;
  logic                   step_fire;
  logic [MEM-1:0]         enc_state;
  logic                   fb_bit;
  logic [NPOLY*PW-1:0]    cfg_held;
  logic [MEM:0]           fb_held;
  logic [NUM_PAR*PW-1:0]  par_held;

  assign step_elig = seq_active & pace_zero & ~blk_start;
  assign step_fire = step_elig & (tail_step | in_valid);
  assign in_ready  = step_elig & ~tail_step;

  assign fb_held  = cfg_held[PW-1:0];
  assign par_held = cfg_held[NPOLY*PW-1:PW];

  rsc_cfg_latch #(.MEM(MEM), .NPOLY(NPOLY)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (blk_start),
    .raw_polys ({cfg_par, cfg_fb}),
    .held_polys(cfg_held)
  );

  rsc_step_pacer #(.STEP_CYCLES(STEP_CYCLES)) u_pace (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (blk_start),
    .fire     (step_fire),
    .pace_zero(pace_zero)
  );

  rsc_block_seq #(.BLK_STEPS(BLK_STEPS), .TAIL_STEPS(MEM), .IDX_W(IDX_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (blk_start),
    .fire      (step_fire),
    .seq_active(seq_active),
    .step_idx  (step_idx),
    .tail_step (tail_step),
    .last_step (last_step)
  );

  rsc_trellis_core #(.MEM(MEM), .NUM_PAR(NUM_PAR)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (blk_start),
    .fire     (step_fire),
    .tail_step(tail_step),
    .in_bit   (in_data),
    .fb_poly  (fb_held),
    .par_poly (par_held),
    .sym_data (sym_data),
    .sym_valid(sym_valid),
    .enc_state(enc_state),
    .fb_bit   (fb_bit)
  );
endmodule

// File: rtl/rsc_encoder_chk.sv
`timescale 1ns/1ps
module rsc_encoder_chk #(
  parameter int unsigned MEM         = 9,
  parameter int unsigned NPOLY       = 4,
  parameter int unsigned IDX_W       = 7,
  parameter int unsigned STEP_CYCLES = 525
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     blk_start,
  input logic                     in_ready,
  input logic                     sym_valid,
  input logic                     sym_sys,
  input logic                     step_fire,
  input logic                     tail_step,
  input logic                     last_step,
  input logic                     seq_active,
  input logic [IDX_W-1:0]         step_idx,
  input logic [MEM-1:0]           enc_state,
  input logic                     fb_bit,
  input logic [NPOLY*(MEM+1)-1:0] cfg_held
);
  localparam int unsigned GAP_W = $clog2(STEP_CYCLES + 1) + 1;
  localparam int unsigned PW    = MEM + 1;

  logic [GAP_W-1:0] gap;
  logic             seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (blk_start) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (step_fire) begin
      gap  <= '0;
      seen <= 1'b1;
    end else if (gap < GAP_W'(STEP_CYCLES)) begin
      gap <= gap + 1'b1;
    end
  end

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!seq_active && !blk_start) |=> !sym_valid);

  a_r5_no_ready_in_tail: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !tail_step);

  a_r6_tail_shift_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (step_fire && tail_step) |=> enc_state[0] == 1'b0);

  a_r6_tail_sys_is_fb: assert property (@(posedge clk) disable iff (!rst_n)
    (step_fire && tail_step) |=> sym_sys == $past(fb_bit));

  a_r6_end_state_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (step_fire && last_step && !blk_start) |=> (enc_state == '0 && !seq_active));

  a_r7_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    blk_start |=> (enc_state == '0 && step_idx == '0 && seq_active && !sym_valid));

  a_r12_sym_after_fire: assert property (@(posedge clk) disable iff (!rst_n)
    step_fire |=> sym_valid);

  a_r12_sym_needs_fire: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid |-> $past(step_fire));

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid |=> !sym_valid);

  a_r8_min_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (step_fire && seen) |-> gap >= GAP_W'(STEP_CYCLES - 1));

  a_r10_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !blk_start |=> $stable(cfg_held));

  a_r11_ends_set: assert property (@(posedge clk) disable iff (!rst_n)
    seq_active |-> (cfg_held[0] && cfg_held[MEM] && cfg_held[PW] && cfg_held[PW+MEM]));
endmodule

bind rsc_encoder rsc_encoder_chk #(
  .MEM(MEM), .NPOLY(NPOLY), .IDX_W(IDX_W), .STEP_CYCLES(STEP_CYCLES)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .blk_start (blk_start),
  .in_ready  (in_ready),
  .sym_valid (sym_valid),
  .sym_sys   (sym_data[0]),
  .step_fire (step_fire),
  .tail_step (tail_step),
  .last_step (last_step),
  .seq_active(seq_active),
  .step_idx  (step_idx),
  .enc_state (enc_state),
  .fb_bit    (fb_bit),
  .cfg_held  (cfg_held)
);

// File: tb/rsc_encoder_bench.sv
`timescale 1ns/1ps
module rsc_encoder_bench;
  localparam int MEM   = 9;
  localparam int NP    = 3;
  localparam int STEPS = 128;
  localparam int INFO  = STEPS - MEM;
  localparam int PACE  = 6;
  localparam int PWB   = NP*(MEM+1);

  localparam logic [MEM:0] FB_A  = 10'h211;
  localparam logic [PWB-1:0] PAR_A = {10'h277, 10'h2CF, 10'h3A5};
  localparam logic [MEM:0] FB_B  = 10'h30B;
  localparam logic [PWB-1:0] PAR_B = {10'h255, 10'h3FF, 10'h201};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic blk_start = 1'b0;
  logic in_data = 1'b0;
  logic in_valid = 1'b0;
  logic [MEM:0] cfg_fb = FB_A;
  logic [PWB-1:0] cfg_par = PAR_A;
  logic in_ready;
  logic [NP:0] sym_data;
  logic sym_valid;

  rsc_encoder #(.STEP_CYCLES(PACE)) u_rsc_encoder (
    .clk(clk), .rst_n(rst_n), .blk_start(blk_start), .in_data(in_data),
    .in_valid(in_valid), .in_ready(in_ready), .cfg_fb(cfg_fb), .cfg_par(cfg_par),
    .sym_data(sym_data), .sym_valid(sym_valid)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  logic bits [INFO];
  logic [NP:0] exp_sym [STEPS];
  logic [NP:0] got_sym [STEPS];
  int got_cyc [STEPS];
  int acc_cyc [STEPS];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog: actual=%0d expected<%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic fill_bits(input int kind);
    logic [6:0] lf;
    lf = 7'h5A;
    for (int i = 0; i < INFO; i++) begin
      case (kind)
        0: bits[i] = 1'b1;
        1: bits[i] = 1'b0;
        2: begin bits[i] = lf[6]; lf = {lf[5:0], lf[6] ^ lf[5]}; end
        default: bits[i] = i[0];
      endcase
    end
  endtask

  // model from the encoding equation (R3, R6, R11)
  task automatic build_exp(input logic [MEM:0] fb_in, input logic [PWB-1:0] par_in);
    logic [MEM:0] ends;
    logic [MEM:0] fb;
    logic [MEM-1:0] d;
    ends = {1'b1, {(MEM-1){1'b0}}, 1'b1};
    fb = fb_in | ends;
    d = '0;
    for (int k = 0; k < STEPS; k++) begin
      logic tap, u, a;
      logic [MEM:0] g;
      tap = ^(fb[MEM:1] & d);
      u = (k < INFO) ? bits[k] : tap;
      a = u ^ tap;
      exp_sym[k][0] = u;
      for (int j = 0; j < NP; j++) begin
        g = par_in[j*(MEM+1) +: MEM+1] | ends;
        exp_sym[k][j+1] = (g[0] & a) ^ (^(g[MEM:1] & d));
      end
      d = {d[MEM-2:0], a};
    end
  endtask

  task automatic run_block(input int kind, input bit stall, input int stop_after, input bit do_check,
                           input bit swap_cfg, input string tag,
                           input logic [MEM:0] efb, input logic [PWB-1:0] epar);
    int idx = 0;
    int n_got = 0;
    int guard = 0;
    bit fired = 0;
    bit prev_v = 0;
    bit tail_rdy = 0;
    bit pulse_bad = 0;
    bit idle_bad = 0;
    fill_bits(kind);
    build_exp(efb, epar);
    @(negedge clk);
    blk_start = 1'b1; in_valid = 1'b1; in_data = 1'b1;
    #1;
    chk(in_ready == 1'b0, "R7", {tag, " in_ready during blk_start"}, int'(in_ready), 0);
    @(negedge clk);
    blk_start = 1'b0; in_valid = 1'b0;
    while (n_got < stop_after && guard < STEPS*PACE*4 + 200) begin
      #1;
      guard++;
      if (fired) idx++;
      if (sym_valid) begin
        if (prev_v) pulse_bad = 1;
        got_sym[n_got] = sym_data;
        got_cyc[n_got] = cyc;
        n_got++;
      end
      prev_v = sym_valid;
      if (in_ready && idx >= INFO) tail_rdy = 1;
      in_valid = (idx < INFO) && !(stall && (cyc % 5 < 2));
      in_data = (idx < INFO) ? bits[idx] : 1'b0;
      fired = in_ready && in_valid;
      if (fired) acc_cyc[idx] = cyc;
      if (swap_cfg && n_got == 10) begin cfg_fb = FB_B; cfg_par = PAR_B; end
      @(negedge clk);
    end
    in_valid = 1'b0;
    if (!do_check) return;
    chk(n_got == stop_after, "R4", {tag, " symbol count"}, n_got, stop_after);
    chk(idx == INFO, "R5", {tag, " bits accepted"}, idx, INFO);
    chk(!tail_rdy, "R5", {tag, " in_ready in tail"}, int'(tail_rdy), 0);
    chk(!pulse_bad, "R9", {tag, " sym_valid longer than one cycle"}, int'(pulse_bad), 0);
    for (int k = 0; k < n_got; k++) begin
      if (k < INFO) begin
        chk(got_sym[k][0] == bits[k], "R2", $sformatf("%s sys bit step %0d", tag, k), int'(got_sym[k][0]), int'(bits[k]));
        chk(got_sym[k] == exp_sym[k], "R3", $sformatf("%s symbol step %0d", tag, k), int'(got_sym[k]), int'(exp_sym[k]));
        chk(got_cyc[k] == acc_cyc[k] + 1, "R12", $sformatf("%s latency step %0d", tag, k), got_cyc[k] - acc_cyc[k], 1);
      end else begin
        chk(got_sym[k] == exp_sym[k], "R6", $sformatf("%s tail symbol step %0d", tag, k), int'(got_sym[k]), int'(exp_sym[k]));
      end
      if (k > 0) begin
        if (stall)
          chk(got_cyc[k] - got_cyc[k-1] >= PACE, "R8", $sformatf("%s gap step %0d", tag, k), got_cyc[k] - got_cyc[k-1], PACE);
        else
          chk(got_cyc[k] - got_cyc[k-1] == PACE, "R8", $sformatf("%s gap step %0d", tag, k), got_cyc[k] - got_cyc[k-1], PACE);
      end
    end
    repeat (3*PACE) begin
      @(negedge clk); #1;
      if (sym_valid || in_ready) idle_bad = 1;
    end
    chk(!idle_bad, "R4", {tag, " idle after block"}, int'(idle_bad), 0);
  endtask

  task automatic t_reset;
    bit bad = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(sym_valid == 1'b0 && in_ready == 1'b0, "R1", "outputs in reset", int'({sym_valid, in_ready}), 0);
    rst_n = 1'b1;
    in_valid = 1'b1;
    repeat (10) begin
      @(negedge clk); #1;
      if (sym_valid || in_ready) bad = 1;
    end
    in_valid = 1'b0;
    chk(!bad, "R1", "idle before first blk_start", int'(bad), 0);
  endtask

  task automatic t_ones;       run_block(0, 0, STEPS, 1, 0, "ones/A", FB_A, PAR_A); endtask
  task automatic t_zeros;      run_block(1, 0, STEPS, 1, 0, "zeros/A", FB_A, PAR_A); endtask
  task automatic t_prbs_stall; run_block(2, 1, STEPS, 1, 0, "prbs-stall/A", FB_A, PAR_A); endtask

  task automatic t_alt_b;
    cfg_fb = FB_B; cfg_par = PAR_B;
    run_block(3, 0, STEPS, 1, 0, "alt/B", FB_B, PAR_B);
  endtask

  // R10: ports switch to set B mid-block, set A must still apply
  task automatic t_cfg_swap;
    cfg_fb = FB_A; cfg_par = PAR_A;
    run_block(2, 0, STEPS, 1, 1, "R10 swap", FB_A, PAR_A);
  endtask

  // R11: end coefficients cleared on the ports
  task automatic t_ends_ignored;
    cfg_fb = FB_A & 10'h1FE;
    cfg_par = PAR_A & {3{10'h1FE}};
    run_block(2, 0, STEPS, 1, 0, "R11 ends", FB_A, PAR_A);
  endtask

  // R7: restart in the middle of a block
  task automatic t_restart;
    cfg_fb = FB_B; cfg_par = PAR_B;
    run_block(0, 0, 20, 0, 0, "R7 partial", FB_B, PAR_B);
    run_block(2, 0, STEPS, 1, 0, "R7 restart", FB_B, PAR_B);
  endtask

  initial begin
    t_reset();
    t_ones();
    t_zeros();
    t_prbs_stall();
    t_alt_b();
    t_cfg_swap();
    t_ends_ignored();
    t_restart();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule